// File: doc/BRIEF.md
# Bit-Writable Distributed RAM

A 64-word by 8-bit memory built from flip-flops, where every write changes exactly one bit and every read returns a full byte. A single address input serves both sides. On the active edge of the write clock, with the write enable high, the 1-bit data input is stored into the bit of the addressed word that the 3-bit bit-select names. All other bits and all other words keep their values.

The read side is purely combinational: the byte output follows the address at all times and does not depend on the write enable. After a write to the word being addressed, the new value appears on the output immediately after the active edge. There is no reset. Each of the eight bit-planes takes its power-up contents from its own parameter, and one further parameter chooses whether writes happen on the rising or the falling edge of the write clock.

Top module: `bwram_bitwr`

## Requirements
- R1: `rdata_o` always equals the 8-bit word stored at `addr_i`. It follows address changes with no clock, whatever the level of `we_i`.
- R2: On an active write-clock edge with `we_i` high, the value of `din_i` is stored into bit `bsel_i` of word `addr_i`. A select of k writes bit k, where bit 0 is the LSB of `rdata_o`.
- R3: During a write, the seven unselected bits of the addressed word keep their values.
- R4: An active edge with `we_i` low changes no stored bit.
- R5: Right after the active edge of a write, `rdata_o` for the written address shows the updated word.
- R6: Bit n of parameter `INIT_BITk` (k = 0..7) is the power-up value of bit k at address n. Every `INIT_BITk` defaults to all zeros.
- R7: With `WCLK_INV` = 0, writes happen on the rising edge of `wclk_i`; with `WCLK_INV` = 1, they happen on the falling edge. The other edge writes nothing.
- R8: A write leaves every word at an address other than `addr_i` unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| wclk_i | input | 1 | Write clock; the active edge is set by `WCLK_INV` |
| we_i | input | 1 | Write enable, active high |
| addr_i | input | 6 | Shared read and write word address |
| bsel_i | input | 3 | Index of the bit to write within the word |
| din_i | input | 1 | Bit value to write |
| rdata_o | output | 8 | Combinational word at `addr_i` |

## Verification
A corrupted bit in this array stays hidden until its address is read. It then shows on `rdata_o` as soon as the address settles, with no clock needed, because the read path is combinational. A wrong decode of the select or the address, or a write on the wrong edge, shows up in one of three places: on the written word right after the edge, on the neighbouring bits of that word, or at a different address the next time that address is read. For this reason the bench reads back both the written word and a second, random word after every edge, and it also probes the word on the inactive edge.

// File: rtl/bwram_pkg.sv
package bwram_pkg;
  localparam int unsigned WORD_W = 8;
  localparam int unsigned SEL_W  = $clog2(WORD_W);
  typedef logic [WORD_W-1:0] word_t;
  typedef logic [SEL_W-1:0]  bsel_t;
endpackage

// File: rtl/bwram_col_dec.sv
// Turns enable + bit select into one write strobe per bit-plane.
module bwram_col_dec
  import bwram_pkg::*;
(
  input  logic  we_i,
  input  bsel_t bsel_i,
  output word_t col_we_o
);
  always_comb begin
    col_we_o = '0;
    if (we_i) col_we_o[bsel_i] = 1'b1;
  end
endmodule

// File: rtl/bwram_plane.sv
// One bit-plane: DEPTH single-bit cells, one write strobe, async read.
module bwram_plane #(
  parameter int unsigned      DEPTH    = 64,
  parameter int unsigned      ADDR_W   = $clog2(DEPTH),
  parameter logic [DEPTH-1:0] INIT     = '0,
  parameter bit               WCLK_INV = 1'b0
) (
  input  logic              wclk_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              din_i,
  output logic              rbit_o
);
  logic [DEPTH-1:0] cell_q = INIT;

  generate
    if (WCLK_INV) begin : g_fall
      always_ff @(negedge wclk_i) begin
        if (we_i) cell_q[addr_i] <= din_i;
      end
    end else begin : g_rise
      always_ff @(posedge wclk_i) begin
        if (we_i) cell_q[addr_i] <= din_i;
      end
    end
  endgenerate

  assign rbit_o = cell_q[addr_i];
endmodule

// File: rtl/bwram_bitwr.sv
module bwram_bitwr
  import bwram_pkg::*;
#(
  parameter int unsigned      DEPTH     = 64,
  parameter int unsigned      ADDR_W    = $clog2(DEPTH),
  parameter logic [DEPTH-1:0] INIT_BIT7 = '0,
  parameter logic [DEPTH-1:0] INIT_BIT6 = '0,
  parameter logic [DEPTH-1:0] INIT_BIT5 = '0,
  parameter logic [DEPTH-1:0] INIT_BIT4 = '0,
  parameter logic [DEPTH-1:0] INIT_BIT3 = '0,
  parameter logic [DEPTH-1:0] INIT_BIT2 = '0,
  parameter logic [DEPTH-1:0] INIT_BIT1 = '0,
  parameter logic [DEPTH-1:0] INIT_BIT0 = '0,
  parameter bit               WCLK_INV  = 1'b0
) (
  input  logic              wclk_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [SEL_W-1:0]  bsel_i,
  input  logic              din_i,
  output logic [WORD_W-1:0] rdata_o
);
  localparam logic [WORD_W-1:0][DEPTH-1:0] INIT_PLANES =
    {INIT_BIT7, INIT_BIT6, INIT_BIT5, INIT_BIT4,
     INIT_BIT3, INIT_BIT2, INIT_BIT1, INIT_BIT0};

  word_t col_we;

  bwram_col_dec i_col_dec (
    .we_i    (we_i),
    .bsel_i  (bsel_i),
    .col_we_o(col_we)
  );

  for (genvar k = 0; k < WORD_W; k++) begin : g_plane
    bwram_plane #(
      .DEPTH   (DEPTH),
      .ADDR_W  (ADDR_W),
      .INIT    (INIT_PLANES[k]),
      .WCLK_INV(WCLK_INV)
    ) i_plane (
      .wclk_i(wclk_i),
      .we_i  (col_we[k]),
      .addr_i(addr_i),
      .din_i (din_i),
      .rbit_o(rdata_o[k])
    );
  end
endmodule

// File: rtl/bwram_bitwr_chk.sv
module bwram_bitwr_chk
  import bwram_pkg::*;
#(
  parameter int unsigned ADDR_W   = 6,
  parameter bit          WCLK_INV = 1'b0
) (
  input logic              wclk_i,
  input logic              we_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic [SEL_W-1:0]  bsel_i,
  input logic              din_i,
  input logic [WORD_W-1:0] rdata_o
);
  logic clk_act;
  logic armed_q = 1'b0;

  assign clk_act = wclk_i ^ WCLK_INV;

  always_ff @(posedge clk_act) armed_q <= 1'b1;

  // R1: a known address always yields a known word
  always_comb begin
    if (!$isunknown(addr_i))
      assert_read_known_R1: assert (!$isunknown(rdata_o));
  end

  assert_bit_written_R2: assert property (@(posedge clk_act) disable iff (!armed_q)
    we_i |=> (addr_i != $past(addr_i)) || (rdata_o[$past(bsel_i)] == $past(din_i)));

  assert_others_kept_R3: assert property (@(posedge clk_act) disable iff (!armed_q)
    we_i |=> (addr_i != $past(addr_i)) ||
             (((rdata_o ^ $past(rdata_o)) & ~(word_t'(1) << $past(bsel_i))) == '0));

  assert_idle_kept_R4: assert property (@(posedge clk_act) disable iff (!armed_q)
    !we_i |=> (addr_i != $past(addr_i)) || (rdata_o == $past(rdata_o)));
endmodule

bind bwram_bitwr bwram_bitwr_chk #(.ADDR_W(ADDR_W), .WCLK_INV(WCLK_INV)) i_chk (.*);

// File: tb/test_bwram_bitwr.sv
module test_bwram_bitwr;
  localparam int DEPTH = 64;
  localparam logic [7:0][63:0] P_INIT = {
    64'hF0E1D2C3B4A59687, 64'h0F1E2D3C4B5A6978, 64'hAAAA5555CCCC3333,
    64'h8000000000000001, 64'h9E3779B97F4A7C15, 64'h0123456789ABCDEF,
    64'hFFFFFFFF00000000, 64'h5A5A5A5AA5A5A5A5};

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic       p_we = 0, n_we = 0, p_din = 0, n_din = 0;
  logic [5:0] p_addr = 0, n_addr = 0;
  logic [2:0] p_sel = 0, n_sel = 0;
  logic [7:0] p_rd, n_rd;
  logic [7:0] ref_p [DEPTH];
  logic [7:0] ref_n [DEPTH];
  int checks = 0, fails = 0;
  bit done = 0;

  bwram_bitwr #(
    .INIT_BIT7(P_INIT[7]), .INIT_BIT6(P_INIT[6]), .INIT_BIT5(P_INIT[5]),
    .INIT_BIT4(P_INIT[4]), .INIT_BIT3(P_INIT[3]), .INIT_BIT2(P_INIT[2]),
    .INIT_BIT1(P_INIT[1]), .INIT_BIT0(P_INIT[0]), .WCLK_INV(1'b0)
  ) i_bwram_bitwr (
    .wclk_i(clk), .we_i(p_we), .addr_i(p_addr), .bsel_i(p_sel),
    .din_i(p_din), .rdata_o(p_rd));

  bwram_bitwr #(.WCLK_INV(1'b1)) i_bwram_bitwr_neg (
    .wclk_i(clk), .we_i(n_we), .addr_i(n_addr), .bsel_i(n_sel),
    .din_i(n_din), .rdata_o(n_rd));

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %02h expected %02h at %0t", req, act, exp, $time);
    end
  endtask

  // rising-edge instance: inputs set after a rising edge, held over the falling edge
  task automatic pos_cycle(input logic [5:0] a, input logic d, input logic w,
                           input logic [2:0] s, input logic [5:0] ra);
    logic [7:0] old;
    @(posedge clk); #3;
    p_addr = a; p_din = d; p_we = w; p_sel = s;
    old = ref_p[a];
    #1 chk("R1", p_rd, old);
    @(negedge clk); #3 chk("R7", p_rd, old);
    @(posedge clk); #3;
    if (w) ref_p[a][s] = d;
    chk(w ? "R5" : "R4", p_rd, ref_p[a]);
    p_we = 0; p_addr = ra;
    #1 chk((ra == a) ? "R3" : "R8", p_rd, ref_p[ra]);
  endtask

  // falling-edge instance: inputs held over a rising edge that must not write
  task automatic neg_cycle(input logic [5:0] a, input logic d, input logic w,
                           input logic [2:0] s, input logic [5:0] ra);
    logic [7:0] old;
    @(negedge clk); #3;
    n_addr = a; n_din = d; n_we = w; n_sel = s;
    old = ref_n[a];
    #1 chk("R1", n_rd, old);
    @(posedge clk); #3 chk("R7", n_rd, old);
    @(negedge clk); #3;
    if (w) ref_n[a][s] = d;
    chk(w ? "R2" : "R4", n_rd, ref_n[a]);
    n_we = 0; n_addr = ra;
    #1 chk((ra == a) ? "R3" : "R8", n_rd, ref_n[ra]);
  endtask

  initial begin
    for (int n = 0; n < DEPTH; n++) begin
      for (int k = 0; k < 8; k++) ref_p[n][k] = P_INIT[k][n];
      ref_n[n] = '0;
    end
    #1;
    for (int n = 0; n < DEPTH; n++) begin  // R6 power-up contents
      p_addr = 6'(n); n_addr = 6'(n);
      #1 chk("R6", p_rd, ref_p[n]);
      chk("R6", n_rd, ref_n[n]);
    end
    for (int a = 0; a < DEPTH; a++)
      for (int k = 0; k < 8; k++) begin
        logic d = 1'(((a * 5 + k * 3) >> 1) & 1);
        pos_cycle(6'(a), d, 1'b1, 3'(k), 6'(a + 1));
        neg_cycle(6'(a), ~d, 1'b1, 3'(k), 6'(a + 7));
      end
    for (int i = 0; i < 2000; i++) begin
      pos_cycle(6'($urandom), 1'($urandom), 1'($urandom), 3'($urandom), 6'($urandom));
      neg_cycle(6'($urandom), 1'($urandom), 1'($urandom), 3'($urandom), 6'($urandom));
    end
    for (int n = 0; n < DEPTH; n++) begin  // R8 full read-back sweep
      p_addr = 6'(n); n_addr = 6'(n);
      #1 chk("R8", p_rd, ref_p[n]);
      chk("R8", n_rd, ref_n[n]);
    end
    done = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    #(20 * 150000);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end
endmodule